// File: doc/BRIEF.md
# Reset-Addressed Field Delay Memory

A dual-clock serial memory that works as a programmable delay line. The write side and the read side each run on their own clock and each keep a sequential address counter. There are no full or empty flags. The distance between the two counters sets the delay between data going in and data coming out. That distance is fixed only by when each side is told to return its counter to address zero.

Each side has two kinds of gating. A step enable stops the counter: with it low, the address holds and nothing moves. A data enable lets the counter keep advancing but suppresses the data. On the write side this leaves the stored word untouched, which allows selective overwrite of a stored field. On the read side it forces the output to zero with the valid flag low, so the word is skipped.

The storage is a simple dual-port array. Either clock may be halted for any length of time and the stored contents are kept.

Top module: `field_delay_mem`

## Requirements
- R1: A high `wr_zero_i` at a write clock edge sets the write address to 0. The next edge with `wr_step_i` and `wr_load_i` high stores `wr_data_i` at address 0.
- R2: At a write edge with `wr_step_i` low, nothing is stored and the write address holds.
- R3: At a write edge with `wr_step_i` high and `wr_load_i` low, the addressed word is left unchanged and the write address still advances by one.
- R4: A high `rd_zero_i` at a read clock edge sets the read address to 0 and drives `rd_valid_o` low and `rd_data_o` to zero after that edge. The next edge with `rd_step_i` high presents the word at address 0.
- R5: At a read edge with `rd_step_i` low, the read address, `rd_data_o` and `rd_valid_o` all hold.
- R6: At a read edge with `rd_step_i` high and `rd_drive_i` low, the read address advances, `rd_valid_o` goes low and `rd_data_o` is all zeros. With `rd_drive_i` high, `rd_valid_o` is high and `rd_data_o` carries the stored word.
- R7: Both address counters wrap from DEPTH-1 to 0.
- R8: The zero inputs take priority over the enables. A write edge with `wr_zero_i` high stores nothing, even when `wr_step_i` and `wr_load_i` are high.
- R9: While `rst_ni` is low and after it is released, `rd_valid_o` is low and `rd_data_o` is zero until the first read.
- R10: Stored words survive either clock being stopped for any length of time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset of both counters and the read output |
| wr_zero_i | input | 1 | Return the write address to 0 (synchronous to wclk_i) |
| wr_step_i | input | 1 | Write step enable; low stops the write address |
| wr_load_i | input | 1 | Write data enable; low masks the store but the address advances |
| wr_data_i | input | WIDTH | Write data |
| rd_zero_i | input | 1 | Return the read address to 0 (synchronous to rclk_i) |
| rd_step_i | input | 1 | Read step enable; low stops the read address and holds the output |
| rd_drive_i | input | 1 | Read data enable; low zeroes the output and the address advances |
| rd_data_o | output | WIDTH | Read data, zero when not valid |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The bench first runs a plain fill and readback of the whole array. A clean result there separates the zero-latency first access after each zero input from an off-by-one in either counter. Read patterns with step-enable gaps are then set against gaps in the data enable. Only the first must keep the output and address still, and only the second must skip a word. The same contrast on the write side, step gaps against load gaps, shows whether a masked write wrongly stops the counter or wrongly stores. Further runs cover writing past the end of the array, a zero input asserted together with the enables, and long stops of each clock in turn. These show the wrap point, the priority of the zero inputs and the retention of stored words.

// File: rtl/fdm_pkg.sv
package fdm_pkg;
  function automatic int addr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/fdm_addr_ctr.sv
module fdm_addr_ctr #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = fdm_pkg::addr_w(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zero_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (zero_i)  addr_q <= '0;
    else if (step_i)  addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fdm_dp_ram.sv
module fdm_dp_ram #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = fdm_pkg::addr_w(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              rclk_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/fdm_rd_stage.sv
module fdm_rd_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             step_i,
  input  logic             drive_i,
  input  logic [WIDTH-1:0] ram_q_i,
  output logic             ram_rd_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rvalid_o
);
  logic valid_q;

  // zero input wins: no fetch on that edge
  assign ram_rd_o = step_i & ~zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (zero_i)  valid_q <= 1'b0;
    else if (step_i)  valid_q <= drive_i;
  end

  assign rvalid_o = valid_q;
  assign rdata_o  = valid_q ? ram_q_i : '0;
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 8
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_zero_i,
  input  logic             wr_step_i,
  input  logic             wr_load_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_zero_i,
  input  logic             rd_step_i,
  input  logic             rd_drive_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_valid_o
);
  localparam int ADDR_W = fdm_pkg::addr_w(DEPTH);

  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              ram_we;
  logic              ram_re;
  logic [WIDTH-1:0]  ram_q;

  assign ram_we = wr_step_i & wr_load_i & ~wr_zero_i;

  fdm_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr_ctr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .zero_i (wr_zero_i),
    .step_i (wr_step_i),
    .addr_o (wr_addr)
  );

  fdm_addr_ctr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd_ctr (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .zero_i (rd_zero_i),
    .step_i (rd_step_i),
    .addr_o (rd_addr)
  );

  fdm_dp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (ram_we),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .rclk_i  (rclk_i),
    .re_i    (ram_re),
    .raddr_i (rd_addr),
    .rdata_o (ram_q)
  );

  fdm_rd_stage #(.WIDTH(WIDTH)) u_rd_stage (
    .clk_i    (rclk_i),
    .rst_ni   (rst_ni),
    .zero_i   (rd_zero_i),
    .step_i   (rd_step_i),
    .drive_i  (rd_drive_i),
    .ram_q_i  (ram_q),
    .ram_rd_o (ram_re),
    .rdata_o  (rd_data_o),
    .rvalid_o (rd_valid_o)
  );
endmodule

// File: rtl/field_delay_mem_chk.sv
module field_delay_mem_chk #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 8,
  parameter int ADDR_W = fdm_pkg::addr_w(DEPTH)
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              wr_zero_i,
  input logic              wr_step_i,
  input logic              rd_zero_i,
  input logic              rd_step_i,
  input logic              rd_drive_i,
  input logic [WIDTH-1:0]  rd_data_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  p_wr_zero_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_zero_i |=> wr_addr == '0);

  p_wr_hold_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_zero_i && !wr_step_i) |=> $stable(wr_addr));

  p_wr_step_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_zero_i && wr_step_i && wr_addr != LAST) |=> wr_addr == $past(wr_addr) + 1'b1);

  p_wr_wrap_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_zero_i && wr_step_i && wr_addr == LAST) |=> wr_addr == '0);

  p_rd_zero_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_zero_i |=> (rd_addr == '0 && !rd_valid_o && rd_data_o == '0));

  p_rd_hold_r5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_zero_i && !rd_step_i) |=> ($stable(rd_addr) && $stable(rd_data_o) && $stable(rd_valid_o)));

  p_rd_skip_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_zero_i && rd_step_i && !rd_drive_i) |=> (!rd_valid_o && rd_data_o == '0));

  p_rd_wrap_r7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_zero_i && rd_step_i && rd_addr == LAST) |=> rd_addr == '0);

  p_idle_zero_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_valid_o |-> rd_data_o == '0);
endmodule

bind field_delay_mem field_delay_mem_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wr_zero_i  (wr_zero_i),
  .wr_step_i  (wr_step_i),
  .rd_zero_i  (rd_zero_i),
  .rd_step_i  (rd_step_i),
  .rd_drive_i (rd_drive_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .wr_addr    (wr_addr),
  .rd_addr    (rd_addr)
);

// File: tb/field_delay_mem_bench.sv
module field_delay_mem_bench;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;

  logic wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic wclk_run = 1'b1, rclk_run = 1'b1;
  logic wr_zero = 0, wr_step = 0, wr_load = 0;
  logic [WIDTH-1:0] wr_data = '0;
  logic rd_zero = 0, rd_step = 0, rd_drive = 0;
  logic [WIDTH-1:0] rd_data;
  logic rd_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench reference state, derived from the requirements
  logic [WIDTH-1:0] m_mem [DEPTH];
  int m_waddr = 0, m_raddr = 0;
  logic [WIDTH-1:0] e_data = '0;
  logic e_valid = 1'b0;

  always #10 if (wclk_run) wclk = ~wclk;   // 50 MHz
  always #14 if (rclk_run) rclk = ~rclk;

  field_delay_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_field_delay_mem (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_zero_i(wr_zero), .wr_step_i(wr_step), .wr_load_i(wr_load), .wr_data_i(wr_data),
    .rd_zero_i(rd_zero), .rd_step_i(rd_step), .rd_drive_i(rd_drive),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] d, input logic v);
    checks++;
    if (rd_data !== d || rd_valid !== v) begin
      errors++;
      $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b", req, rd_data, rd_valid, d, v);
    end
  endtask

  task automatic wr(input logic z, input logic s, input logic l, input logic [WIDTH-1:0] d);
    @(negedge wclk);
    wr_zero = z; wr_step = s; wr_load = l; wr_data = d;
    @(posedge wclk);
    #1 wr_zero = 0; wr_step = 0; wr_load = 0;
    if (z) m_waddr = 0;
    else if (s) begin
      if (l) m_mem[m_waddr] = d;
      m_waddr = (m_waddr == DEPTH-1) ? 0 : m_waddr + 1;
    end
  endtask

  task automatic rd(input string req, input logic z, input logic s, input logic o);
    @(negedge rclk);
    rd_zero = z; rd_step = s; rd_drive = o;
    @(posedge rclk);
    #2 rd_zero = 0; rd_step = 0; rd_drive = 0;
    if (z) begin m_raddr = 0; e_valid = 0; e_data = '0; end
    else if (s) begin
      e_valid = o;
      e_data  = o ? m_mem[m_raddr] : '0;
      m_raddr = (m_raddr == DEPTH-1) ? 0 : m_raddr + 1;
    end
    check(req, e_data, e_valid);
  endtask

  task automatic t_reset;
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R9: data=%h valid=%b expected data=00 valid=0", rd_data, rd_valid);
    end
  endtask

  task automatic t_fill;  // R1 R4
    wr(1, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++) wr(0, 1, 1, WIDTH'(i * 7 + 3));
    rd("R4", 1, 1, 1);
    for (int i = 0; i < DEPTH; i++) rd("R1", 0, 1, 1);
  endtask

  task automatic t_step_gap;  // R2
    wr(1, 0, 0, 0);
    wr(0, 1, 1, 8'h11);
    wr(0, 0, 1, 8'hEE);
    wr(0, 1, 1, 8'h22);
    rd("R4", 1, 0, 0);
    rd("R2", 0, 1, 1);
    rd("R2", 0, 1, 1);
    rd("R2", 0, 1, 1);
  endtask

  task automatic t_load_mask;  // R3
    wr(1, 0, 0, 0);
    wr(0, 1, 1, 8'h55);
    wr(0, 1, 0, 8'h66);
    wr(0, 1, 1, 8'h77);
    rd("R4", 1, 0, 0);
    for (int i = 0; i < 4; i++) rd("R3", 0, 1, 1);
  endtask

  task automatic t_zero_priority;  // R8
    wr(1, 1, 1, 8'h99);
    wr(0, 0, 0, 0);
    rd("R8", 1, 1, 1);
    for (int i = 0; i < 4; i++) rd("R8", 0, 1, 1);
  endtask

  task automatic t_rd_hold;  // R5
    rd("R4", 1, 0, 0);
    rd("R5", 0, 1, 1);
    rd("R5", 0, 0, 1);
    rd("R5", 0, 0, 0);
    rd("R5", 0, 1, 1);
  endtask

  task automatic t_skip;  // R6
    rd("R4", 1, 0, 0);
    rd("R6", 0, 1, 1);
    rd("R6", 0, 1, 0);
    rd("R6", 0, 1, 1);
  endtask

  task automatic t_wrap;  // R7
    wr(1, 0, 0, 0);
    for (int i = 0; i < DEPTH + 3; i++) wr(0, 1, 1, WIDTH'(i) ^ 8'hA5);
    rd("R4", 1, 0, 0);
    for (int i = 0; i < DEPTH + 3; i++) rd("R7", 0, 1, 1);
  endtask

  task automatic t_clock_stop;  // R10
    rclk_run = 0;
    wr(1, 0, 0, 0);
    for (int i = 0; i < 6; i++) wr(0, 1, 1, 8'hC0 + WIDTH'(i));
    repeat (500) @(posedge wclk);
    rclk_run = 1;
    wclk_run = 0;
    #20000;
    rd("R10", 1, 0, 0);
    for (int i = 0; i < 8; i++) rd("R10", 0, 1, 1);
    wclk_run = 1;
  endtask

  initial begin
    #1 t_reset();
    repeat (3) @(posedge wclk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(posedge rclk);
    t_reset();
    t_fill();
    t_step_gap();
    t_load_mask();
    t_zero_priority();
    t_rd_hold();
    t_skip();
    t_wrap();
    t_clock_stop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule